// File: doc/BRIEF.md
# Transmit Descriptor Poll and Interrupt Moderation Controller

This block decides when the transmit side of a network controller looks at its next descriptor, and when a finished frame is reported to the host by interrupt. While transmission is enabled it sends a single-cycle poll request to a descriptor-read agent and waits for a response that carries an ownership flag. If the device does not own the descriptor, a programmable 16-bit interval is counted before the next poll. If it does own it, a one-cycle fill request starts the transmission. As soon as that frame completes, the next descriptor is polled at once, so frames sent back to back have no interval between them.

Each frame completion arrives as a status strobe with an error flag and a last-of-sequence flag. It sets a sticky done flag. An interrupt cause flag is set unless the frame is moderated. One control suppresses the cause for every successful frame. A second control suppresses it for successful frames that are not the last of their sequence. Frames with an error always raise the cause. The host clears both flags by writing one. Register bits appear as plain ports.

Top module: `tx_poll_irq_ctrl`

## Requirements
- R1: After reset `desc_req`, `fill_req`, `done_flag` and `irq` are 0. While `run` is 0 the block issues no poll request.
- R2: When `run` rises with the block idle, `desc_req` is high in the cycle after `run` is first sampled high.
- R3: `desc_req` is a single-cycle pulse. After it, no further poll is issued until a response (`desc_rsp_valid`=1) is received.
- R4: A response with `desc_rsp_own`=0 starts the interval count. The next `desc_req` is high max(`poll_interval`,1)+1 cycles after the cycle in which the response was sampled.
- R5: A response with `desc_rsp_own`=1 makes `fill_req` high for exactly the following cycle. No poll is issued after that until a completion strobe arrives.
- R6: A completion strobe (`cmpl_valid`=1) during a transmission makes `desc_req` high in the next cycle, whatever the value of `poll_interval`.
- R7: Every completion strobe sets `done_flag` in the next cycle, with or without error. The flag stays set until it is cleared.
- R8: `irq` is 1 exactly when the interrupt cause flag is set, `irq_en`=1 and `irq_mask`=0. A change of `irq_en` or `irq_mask` shows on `irq` in the same cycle.
- R9: With `sup_ok`=1, a completion with `cmpl_err`=0 does not set the interrupt cause. This holds whatever the value of `last_only`.
- R10: With `last_only`=1 and `sup_ok`=0, a completion with `cmpl_err`=0 sets the interrupt cause only if `cmpl_last`=1.
- R11: A completion with `cmpl_err`=1 always sets the interrupt cause, whatever the suppression controls are.
- R12: A `done_clr` pulse clears `done_flag` and the interrupt cause, so `irq` is 0 in the next cycle. If a completion arrives in the same cycle as the clear, the completion wins and `done_flag` is 1.
- R13: If `run` falls while the block waits out a poll interval, it goes idle and issues no further poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transmit enable |
| poll_interval | input | 16 | Idle cycles between unsuccessful polls |
| desc_req | output | 1 | Single-cycle descriptor poll request |
| desc_rsp_valid | input | 1 | Poll response strobe |
| desc_rsp_own | input | 1 | Ownership flag returned with the response |
| fill_req | output | 1 | Single-cycle request to fill the FIFO and start a transmission |
| cmpl_valid | input | 1 | Frame completion strobe, after status writeback |
| cmpl_err | input | 1 | Completed frame had an error |
| cmpl_last | input | 1 | Completed frame is the last of its sequence |
| sup_ok | input | 1 | Suppress interrupts for successful frames |
| last_only | input | 1 | Interrupt only on the last successful frame of a sequence |
| irq_en | input | 1 | Global interrupt enable |
| irq_mask | input | 1 | Transmit interrupt mask |
| done_clr | input | 1 | Write-one-to-clear pulse for the done flag |
| done_flag | output | 1 | Sticky transmit-done flag |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that the descriptor-read agent answers each poll once, and only after the request pulse. They also assume that completion and clear strobes last one cycle. The bench drives every strobe for exactly one cycle from the falling edge. It answers a poll only after the request has been seen and one more cycle has passed. It sends a completion only while a fill has been granted, except in the table walk, where the sequencer is idle and only the interrupt logic is exercised.

// File: rtl/tx_poll_pkg.sv
package tx_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_POLL = 3'd2,
    ST_RESP = 3'd3,
    ST_FILL = 3'd4,
    ST_XMIT = 3'd5
  } tx_state_e;
endpackage

// File: rtl/tx_poll_timer.sv
module tx_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             count_en,
  input  logic [CNT_W-1:0] interval,
  output logic             expired
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + EXT_W'(1);
  // expiry once this cycle would complete the interval (minimum one cycle)
  assign expired  = count_en && (cnt_plus >= {1'b0, interval});

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = '0;
    else if (count_en) cnt_d = cnt_plus[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tx_poll_fsm.sv
module tx_poll_fsm
  import tx_poll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      timer_expired,
  input  logic      rsp_valid,
  input  logic      rsp_own,
  input  logic      cmpl_valid,
  output tx_state_e state,
  output logic      desc_req,
  output logic      fill_req
);
  tx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (run) state_d = ST_POLL;
      ST_WAIT: begin
        if (!run)               state_d = ST_IDLE;
        else if (timer_expired) state_d = ST_POLL;
      end
      ST_POLL: state_d = ST_RESP;
      ST_RESP: begin
        if (rsp_valid) state_d = rsp_own ? ST_FILL : ST_WAIT;
      end
      ST_FILL: state_d = ST_XMIT;
      ST_XMIT: begin
        // end-of-frame poll: no interval after a completed frame
        if (cmpl_valid) state_d = run ? ST_POLL : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign desc_req = (state_q == ST_POLL);
  assign fill_req = (state_q == ST_FILL);
endmodule

// File: rtl/tx_irq_moderator.sv
module tx_irq_moderator (
  input  logic clk,
  input  logic rst_n,
  input  logic cmpl_valid,
  input  logic cmpl_err,
  input  logic cmpl_last,
  input  logic sup_ok,
  input  logic last_only,
  input  logic irq_en,
  input  logic irq_mask,
  input  logic done_clr,
  output logic done_flag,
  output logic irq
);
  logic done_q, done_d;
  logic cause_q, cause_d;
  logic ok_reports;
  logic cause_set;

  // successful frames report unless suppressed outright or not last in last-only mode
  assign ok_reports = !sup_ok && (!last_only || cmpl_last);
  assign cause_set  = cmpl_valid && (cmpl_err || ok_reports);

  always_comb begin
    done_d  = done_q;
    cause_d = cause_q;
    if (done_clr) begin
      done_d  = 1'b0;
      cause_d = 1'b0;
    end
    if (cmpl_valid) done_d  = 1'b1;
    if (cause_set)  cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      cause_q <= cause_d;
    end
  end

  assign done_flag = done_q;
  assign irq       = cause_q && irq_en && !irq_mask;
endmodule

// File: rtl/tx_poll_irq_ctrl.sv
module tx_poll_irq_ctrl
  import tx_poll_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] poll_interval,
  output logic             desc_req,
  input  logic             desc_rsp_valid,
  input  logic             desc_rsp_own,
  output logic             fill_req,
  input  logic             cmpl_valid,
  input  logic             cmpl_err,
  input  logic             cmpl_last,
  input  logic             sup_ok,
  input  logic             last_only,
  input  logic             irq_en,
  input  logic             irq_mask,
  input  logic             done_clr,
  output logic             done_flag,
  output logic             irq
);
  tx_state_e state;
  logic      timer_expired;
  logic      in_wait;

  assign in_wait = (state == ST_WAIT);

  tx_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (!in_wait),
    .count_en (in_wait),
    .interval (poll_interval),
    .expired  (timer_expired)
  );

  tx_poll_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .timer_expired (timer_expired),
    .rsp_valid     (desc_rsp_valid),
    .rsp_own       (desc_rsp_own),
    .cmpl_valid    (cmpl_valid),
    .state         (state),
    .desc_req      (desc_req),
    .fill_req      (fill_req)
  );

  tx_irq_moderator u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmpl_valid (cmpl_valid),
    .cmpl_err   (cmpl_err),
    .cmpl_last  (cmpl_last),
    .sup_ok     (sup_ok),
    .last_only  (last_only),
    .irq_en     (irq_en),
    .irq_mask   (irq_mask),
    .done_clr   (done_clr),
    .done_flag  (done_flag),
    .irq        (irq)
  );
endmodule

// File: rtl/tx_poll_irq_chk.sv
module tx_poll_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic desc_req,
  input logic desc_rsp_valid,
  input logic desc_rsp_own,
  input logic fill_req,
  input logic cmpl_valid,
  input logic cmpl_err,
  input logic sup_ok,
  input logic irq_en,
  input logic irq_mask,
  input logic done_clr,
  input logic done_flag,
  input logic irq
);
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req |=> !desc_req);

  assert_fill_after_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> $past(desc_rsp_valid && desc_rsp_own));

  assert_fill_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req && !desc_req);

  assert_no_poll_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !desc_req && !fill_req && !$past(cmpl_valid)) |=> !desc_req || $past(run));

  assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |=> done_flag);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag && irq_en && !irq_mask));

  assert_sup_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_flag && cmpl_valid && !cmpl_err && sup_ok) |=> !irq);

  assert_err_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_err) |=> (irq || !irq_en || irq_mask));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !cmpl_valid) |=> (!done_flag && !irq));
endmodule

bind tx_poll_irq_ctrl tx_poll_irq_chk u_chk (.*);

// File: tb/tx_poll_irq_ctrl_tb.sv
module tx_poll_irq_ctrl_tb;
  localparam int LIMIT = 5000;
  // {err, last, sup_ok, last_only, expected irq}
  localparam logic [4:0] VEC [8] = '{
    5'b00001, 5'b10001, 5'b00100, 5'b10101,
    5'b00010, 5'b01011, 5'b10011, 5'b01110
  };

  logic clk, rst_n, run;
  logic [15:0] poll_interval;
  logic desc_req, desc_rsp_valid, desc_rsp_own, fill_req;
  logic cmpl_valid, cmpl_err, cmpl_last, sup_ok, last_only;
  logic irq_en, irq_mask, done_clr, done_flag, irq;
  int checks, fails, n;
  bit seen;

  tx_poll_irq_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advances falling edges until the chosen output is high; strobes last one cycle
  task automatic wait_for(input bit pick_fill, output int cnt);
    cnt = 0;
    while (((pick_fill ? fill_req : desc_req) !== 1'b1) && cnt < LIMIT) begin
      @(negedge clk);
      cnt++;
      desc_rsp_valid = 1'b0;
      cmpl_valid     = 1'b0;
      done_clr       = 1'b0;
    end
  endtask

  task automatic pulse_neg(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      desc_rsp_valid = 1'b0;
      cmpl_valid     = 1'b0;
      done_clr       = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; run = 1'b0; poll_interval = 16'd5;
    desc_rsp_valid = 1'b0; desc_rsp_own = 1'b0;
    cmpl_valid = 1'b0; cmpl_err = 1'b0; cmpl_last = 1'b0;
    sup_ok = 1'b0; last_only = 1'b0; irq_en = 1'b1; irq_mask = 1'b0; done_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 desc_req", desc_req, 0);
    check("R1 fill_req", fill_req, 0);
    check("R1 done_flag", done_flag, 0);
    check("R1 irq", irq, 0);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (desc_req) seen = 1'b1; end
    check("R1 no poll while run low", seen, 0);

    // table walk: interrupt moderation with the sequencer idle
    for (int v = 0; v < 8; v++) begin
      done_clr = 1'b1;
      pulse_neg(1);
      {cmpl_err, cmpl_last, sup_ok, last_only} = VEC[v][4:1];
      cmpl_valid = 1'b1;
      pulse_neg(1);
      check($sformatf("R7 done vec%0d", v), done_flag, 1);
      check($sformatf("R9/R10/R11 irq vec%0d", v), irq, VEC[v][0]);
    end
    sup_ok = 1'b0; last_only = 1'b0; cmpl_err = 1'b0; cmpl_last = 1'b0;

    // R8: enable and mask gate the output combinationally
    done_clr = 1'b1; pulse_neg(1);
    irq_mask = 1'b1; cmpl_err = 1'b1; cmpl_valid = 1'b1;
    pulse_neg(1);
    check("R8 masked irq", irq, 0);
    check("R8 masked done", done_flag, 1);
    irq_mask = 1'b0; #1;
    check("R8 unmasked irq", irq, 1);
    irq_en = 1'b0; #1;
    check("R8 disabled irq", irq, 0);
    irq_en = 1'b1; cmpl_err = 1'b0;

    // R12: clear, and completion winning over a clear in the same cycle
    done_clr = 1'b1; pulse_neg(1);
    check("R12 clear done", done_flag, 0);
    check("R12 clear irq", irq, 0);
    done_clr = 1'b1; cmpl_valid = 1'b1; pulse_neg(1);
    check("R12 completion wins", done_flag, 1);
    done_clr = 1'b1; pulse_neg(1);

    // R2 first poll
    run = 1'b1;
    wait_for(1'b0, n);
    check("R2 first poll delay", n, 1);
    pulse_neg(1);
    check("R3 single-cycle request", desc_req, 0);
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin pulse_neg(1); if (desc_req) seen = 1'b1; end
    check("R3 no repoll before response", seen, 0);

    // R4 interval 5
    desc_rsp_valid = 1'b1; desc_rsp_own = 1'b0;
    wait_for(1'b0, n);
    check("R4 interval 5", n, 6);
    pulse_neg(1);
    poll_interval = 16'd0;
    desc_rsp_valid = 1'b1; desc_rsp_own = 1'b0;
    wait_for(1'b0, n);
    check("R4 interval 0", n, 2);
    pulse_neg(1);

    // R5 ownership granted
    desc_rsp_valid = 1'b1; desc_rsp_own = 1'b1;
    wait_for(1'b1, n);
    check("R5 fill delay", n, 1);
    desc_rsp_own = 1'b0;
    pulse_neg(1);
    check("R5 fill single cycle", fill_req, 0);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin pulse_neg(1); if (desc_req) seen = 1'b1; end
    check("R5 no poll during frame", seen, 0);

    // R6 end-of-frame poll with a long interval
    poll_interval = 16'd300;
    cmpl_valid = 1'b1; cmpl_err = 1'b0; cmpl_last = 1'b1;
    wait_for(1'b0, n);
    check("R6 poll right after completion", n, 1);
    check("R7 done after frame", done_flag, 1);
    check("R8 irq after frame", irq, 1);
    pulse_neg(1);
    desc_rsp_valid = 1'b1; desc_rsp_own = 1'b0;
    wait_for(1'b0, n);
    check("R4 interval 300", n, 301);
    pulse_neg(1);

    // R13 run falls during the interval
    desc_rsp_valid = 1'b1; desc_rsp_own = 1'b0;
    pulse_neg(1);
    run = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 350; i++) begin pulse_neg(1); if (desc_req) seen = 1'b1; end
    check("R13 no poll after run low", seen, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule